// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a parallel flash device. It waits for an embedded program or erase operation to finish. After `start`, it issues status read cycles, two at a time. It compares the busy-toggle bit (bit 6) of the two words in each pair. When the bit did not change, the operation has finished and the next array read returns real data. When the bit changed, the block looks at the time-limit flag (bit 5) of the second word. If the flag is set, the block reads one more pair to rule out a finish that coincided with the time limit. If the flag is set again while the bit still toggles, the block reports a failure and asks for the reset command sequence. A count limit on read pairs ends a poll that never settles.

As an option, chosen with `chk_dq3` at `start`, the block first checks whether a further sector-erase command was taken. It reads the erase-window bit (bit 3) once, waits until other logic reports on `cmd_sent` that it wrote the command, then reads the bit again. It flags the command as possibly rejected when either read showed the window closed. Toggle polling follows.

Status reads use a valid/ready pair. `rd_req` is the valid and `rd_ack` is the ready. The request stays high, and its data is awaited, until the flash side acknowledges it. `rd_data` is taken only in the cycle where both are high. The flash side may hold off a read for any number of cycles. The block never raises a new request in the cycle after an accepted one, so output-enable returns high between any two reads.

Top module: `tgl_poll_ctrl`

## Requirements
- R1: During and right after reset, `rd_req`, `done`, `err`, `rst_req` and `erase_rej` are 0, and `ce_n` and `oe_n` are 1.
- R2: Once raised, `rd_req` stays high until the cycle in which `rd_ack` is seen high. `oe_n` is low exactly while `rd_req` is high. `ce_n` is low for the whole poll, from the cycle after `start` is accepted until the outcome pulse.
- R3: After each accepted read, `rd_req` and `oe_n` return to their idle levels (0 and 1) for at least one cycle before the next read.
- R4: Toggle reads come in pairs. When bit 6 of the two words matches, `done` is high in the second cycle after the cycle that accepted the second read.
- R5: When bit 6 differs within a pair, bit 5 of the second word is 1, and no pair of this poll has yet seen that, exactly one more pair is read.
- R6: When bit 6 differs and bit 5 of the second word is 1 in a pair that follows such a retry, `err` and `rst_req` are pulsed together in the second cycle after that read.
- R7: With `MAX_PAIRS` greater than 0, a poll whose pairs keep toggling without bit 5 ends with `err` alone (without `rst_req`). This happens at the pair that makes the total number of toggling pairs reach `MAX_PAIRS`.
- R8: `done` and `err` last one cycle and never occur together. In that cycle `ce_n` is already 1, and the next `start` is accepted.
- R9: `start` has no effect while a poll is in progress.
- R10: With `chk_dq3` high at `start`, one read comes first, then a wait for `cmd_sent`, then a second read. `erase_rej` pulses one cycle after that second read is accepted if bit 3 was 1 in either word. Toggle polling then begins.
- R11: A matching bit 6 ends the poll with `done` even when bit 5 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a poll (taken only when idle) |
| chk_dq3 | input | 1 | Run the erase-window check before polling |
| cmd_sent | input | 1 | Other logic has written the further erase command |
| rd_req | output | 1 | Status read valid |
| rd_ack | input | 1 | Status read ready; data valid in this cycle |
| rd_data | input | DW | Status word |
| ce_n | output | 1 | Chip enable, active low |
| oe_n | output | 1 | Output enable, active low |
| done | output | 1 | Operation finished (one-cycle pulse) |
| err | output | 1 | Poll failed (one-cycle pulse) |
| rst_req | output | 1 | Reset command sequence needed (with `err`) |
| erase_rej | output | 1 | Further erase command possibly rejected (pulse) |

## Verification
The outcome pulses (`done`, `err`, `rst_req`) are due two cycles after the cycle that accepts the last read of the deciding pair. `erase_rej` is due one cycle after the second window read. The bench records the cycle of every acknowledge it gives. It then compares each pulse's arrival cycle with that record plus the fixed offset. All sampling happens on the falling edge, so registered outputs have settled. Responder latency is swept from zero to two cycles, which moves the acknowledge cycles while the offsets stay fixed.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef enum logic [3:0] {
    TS_IDLE, TS_PRE, TS_WCMD, TS_POST, TS_GAP0,
    TS_RD1, TS_GAP1, TS_RD2, TS_EVAL
  } tp_state_e;

  typedef enum logic [1:0] {
    TV_MORE, TV_DONE, TV_TMO, TV_LIM
  } tp_verdict_e;

  localparam int unsigned TGL_POS_DEF = 6;
  localparam int unsigned TMO_POS_DEF = 5;
  localparam int unsigned WIN_POS_DEF = 3;
endpackage

// File: rtl/tp_seq.sv
module tp_seq
  import tp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        chk_dq3,
  input  logic        cmd_sent,
  input  logic        rd_ack,
  input  tp_verdict_e verdict,
  output logic        rd_req,
  output logic        ce_n,
  output logic        launch,
  output logic        cap_pre,
  output logic        cap_post,
  output logic        cap_a,
  output logic        cap_b,
  output logic        eval
);
  tp_state_e state, nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= TS_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      TS_IDLE: if (start) nxt = chk_dq3 ? TS_PRE : TS_RD1;
      TS_PRE:  if (rd_ack) nxt = TS_WCMD;
      TS_WCMD: if (cmd_sent) nxt = TS_POST;
      TS_POST: if (rd_ack) nxt = TS_GAP0;
      TS_GAP0: nxt = TS_RD1;
      TS_RD1:  if (rd_ack) nxt = TS_GAP1;
      TS_GAP1: nxt = TS_RD2;
      TS_RD2:  if (rd_ack) nxt = TS_EVAL;
      TS_EVAL: nxt = (verdict == TV_MORE) ? TS_RD1 : TS_IDLE;
      default: nxt = TS_IDLE;
    endcase
  end

  assign rd_req   = (state == TS_PRE) || (state == TS_POST) ||
                    (state == TS_RD1) || (state == TS_RD2);
  assign ce_n     = (state == TS_IDLE);
  assign launch   = (state == TS_IDLE) && start;
  assign cap_pre  = (state == TS_PRE)  && rd_ack;
  assign cap_post = (state == TS_POST) && rd_ack;
  assign cap_a    = (state == TS_RD1)  && rd_ack;
  assign cap_b    = (state == TS_RD2)  && rd_ack;
  assign eval     = (state == TS_EVAL);
endmodule

// File: rtl/tp_pair_cnt.sv
module tp_pair_cnt #(
  parameter int unsigned MAX_PAIRS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int unsigned CW = $clog2(MAX_PAIRS + 2);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  generate
    if (MAX_PAIRS > 0) begin : g_limit
      assign last = (cnt >= CW'(MAX_PAIRS - 1));
    end else begin : g_unlimited
      logic unused_cnt;
      assign unused_cnt = ^cnt;
      assign last = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/tp_judge.sv
module tp_judge
  import tp_pkg::*;
#(
  parameter int unsigned MAX_PAIRS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch,
  input  logic        cap_a,
  input  logic        cap_b,
  input  logic        eval,
  input  logic        tgl_bit,
  input  logic        tmo_bit,
  output tp_verdict_e verdict
);
  logic first_tgl, sec_tgl, sec_tmo, retried, same, last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_tgl <= 1'b0;
      sec_tgl   <= 1'b0;
      sec_tmo   <= 1'b0;
    end else begin
      if (cap_a) first_tgl <= tgl_bit;
      if (cap_b) begin
        sec_tgl <= tgl_bit;
        sec_tmo <= tmo_bit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       retried <= 1'b0;
    else if (launch)                  retried <= 1'b0;
    else if (eval && !same && sec_tmo) retried <= 1'b1;
  end

  assign same = (first_tgl == sec_tgl);

  always_comb begin
    if (same)                    verdict = TV_DONE;
    else if (sec_tmo && retried) verdict = TV_TMO;
    else if (sec_tmo)            verdict = TV_MORE;
    else if (last)               verdict = TV_LIM;
    else                         verdict = TV_MORE;
  end

  tp_pair_cnt #(.MAX_PAIRS(MAX_PAIRS)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (launch),
    .inc  (eval && (verdict == TV_MORE)),
    .last (last)
  );
endmodule

// File: rtl/tp_win_chk.sv
module tp_win_chk (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_pre,
  input  logic cap_post,
  input  logic win_bit,
  output logic erase_rej
);
  logic pre_shut;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_shut  <= 1'b0;
      erase_rej <= 1'b0;
    end else begin
      if (cap_pre) pre_shut <= win_bit;
      erase_rej <= cap_post && (win_bit || pre_shut);
    end
  end
endmodule

// File: rtl/tgl_poll_ctrl.sv
module tgl_poll_ctrl
  import tp_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter int unsigned MAX_PAIRS = 64,
  parameter int unsigned TGL_POS   = TGL_POS_DEF,
  parameter int unsigned TMO_POS   = TMO_POS_DEF,
  parameter int unsigned WIN_POS   = WIN_POS_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          chk_dq3,
  input  logic          cmd_sent,
  output logic          rd_req,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          ce_n,
  output logic          oe_n,
  output logic          done,
  output logic          err,
  output logic          rst_req,
  output logic          erase_rej
);
  tp_verdict_e verdict;
  logic launch, cap_pre, cap_post, cap_a, cap_b, eval;
  logic unused_rd;

  assign unused_rd = ^rd_data;

  tp_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .chk_dq3 (chk_dq3),
    .cmd_sent(cmd_sent),
    .rd_ack  (rd_ack),
    .verdict (verdict),
    .rd_req  (rd_req),
    .ce_n    (ce_n),
    .launch  (launch),
    .cap_pre (cap_pre),
    .cap_post(cap_post),
    .cap_a   (cap_a),
    .cap_b   (cap_b),
    .eval    (eval)
  );

  tp_judge #(.MAX_PAIRS(MAX_PAIRS)) u_judge (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (launch),
    .cap_a  (cap_a),
    .cap_b  (cap_b),
    .eval   (eval),
    .tgl_bit(rd_data[TGL_POS]),
    .tmo_bit(rd_data[TMO_POS]),
    .verdict(verdict)
  );

  tp_win_chk u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_pre  (cap_pre),
    .cap_post (cap_post),
    .win_bit  (rd_data[WIN_POS]),
    .erase_rej(erase_rej)
  );

  assign oe_n = !rd_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      err     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      done    <= eval && (verdict == TV_DONE);
      err     <= eval && ((verdict == TV_TMO) || (verdict == TV_LIM));
      rst_req <= eval && (verdict == TV_TMO);
    end
  end
endmodule

// File: rtl/tp_poll_chk.sv
module tp_poll_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_req,
  input logic rd_ack,
  input logic ce_n,
  input logic oe_n,
  input logic done,
  input logic err,
  input logic rst_req,
  input logic erase_rej
);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req);

  // R2
  oe_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !ce_n);

  // R3
  read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_ack |=> !rd_req && oe_n);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  // R8
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R8
  outcome_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> ce_n);

  // R6
  reset_with_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> err);

  // R10
  rej_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_rej |-> $past(rd_req && rd_ack));
endmodule

bind tgl_poll_ctrl tp_poll_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_req   (rd_req),
  .rd_ack   (rd_ack),
  .ce_n     (ce_n),
  .oe_n     (oe_n),
  .done     (done),
  .err      (err),
  .rst_req  (rst_req),
  .erase_rej(erase_rej)
);

// File: tb/tgl_poll_ctrl_bench.sv
`timescale 1ns/1ps
module tgl_poll_ctrl_bench;
  localparam int MAXP = 4;
  localparam int NEVER = 999;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, chk_dq3 = 1'b0, cmd_sent = 1'b0;
  logic rd_req, rd_ack = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic ce_n, oe_n, done, err, rst_req, erase_rej;

  always #2.5 clk = ~clk;

  tgl_poll_ctrl #(.DW(8), .MAX_PAIRS(MAXP)) u_tgl_poll_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .chk_dq3(chk_dq3),
    .cmd_sent(cmd_sent), .rd_req(rd_req), .rd_ack(rd_ack),
    .rd_data(rd_data), .ce_n(ce_n), .oe_n(oe_n), .done(done),
    .err(err), .rst_req(rst_req), .erase_rej(erase_rej)
  );

  int total = 0, bad = 0;
  int cyc = 0, r = 0, w = 0, lat = 0, cmd_wait = 0;
  int rsp_n = 0, rsp_t = NEVER, rsp_off = 0;
  bit pre_v, post_v, chk_mode, poke, poked, cmd_given, go;
  int ack_cyc, ack1_cyc, end_cyc, rej_cyc;
  bit got_done, got_err, got_rst, got_rej;
  bit gap_bad, oe_bad, pulse_bad, req_prev, done_prev, err_prev;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit tg(input int k, input int n);
    return (k < n) ? k[0] : n[0];
  endfunction

  function automatic logic [7:0] rsp_word(input int idx);
    logic [7:0] v;
    int k;
    v = 8'h11;
    if (idx < rsp_off) begin
      v[3] = (idx == 0) ? pre_v : post_v;
    end else begin
      k = idx - rsp_off;
      v[6] = tg(k, rsp_n);
      v[5] = (k >= rsp_t);
    end
    return v;
  endfunction

  // kind: 0 done, 1 timeout with reset request, 2 pair limit
  function automatic void expect_run(input int n, input int t,
                                     output int kind, output int reads);
    int cnt;
    bit ret;
    cnt = 0; ret = 0; kind = -1; reads = 0;
    for (int p = 0; p < 64 && kind < 0; p++) begin
      bit a, b, d5;
      a = tg(2*p, n);
      b = tg(2*p+1, n);
      d5 = ((2*p+1) >= t);
      reads = 2*p + 2;
      if (a == b) kind = 0;
      else if (d5 && ret) kind = 1;
      else if (d5) begin ret = 1; cnt++; end
      else if (cnt + 1 >= MAXP) kind = 2;
      else cnt++;
    end
  endfunction

  // responder and monitor, all on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        if (req_prev && rd_ack && rd_req) gap_bad = 1;
        if (oe_n != !rd_req) oe_bad = 1;
        if (!oe_n && ce_n) oe_bad = 1;
        if (done) begin
          if (done_prev) pulse_bad = 1;
          got_done = 1; end_cyc = cyc;
        end
        if (err) begin
          if (err_prev) pulse_bad = 1;
          got_err = 1; end_cyc = cyc;
        end
        if (done && err) pulse_bad = 1;
        if (rst_req) got_rst = 1;
        if (erase_rej) begin got_rej = 1; rej_cyc = cyc; end
        done_prev = done; err_prev = err;
        if (rd_ack) rd_ack = 0;
        else if (rd_req) begin
          if (w >= lat) begin
            rd_ack = 1; rd_data = rsp_word(r); r++; ack_cyc = cyc;
            if (r == 2) ack1_cyc = cyc;
            w = 0;
          end else w++;
        end else w = 0;
        if (cmd_sent) cmd_sent = 0;
        else if (chk_mode && r == 1 && !cmd_given) begin
          if (cmd_wait == 2) begin cmd_sent = 1; cmd_given = 1; end
          else cmd_wait++;
        end
        if (start) start = 0;
        else if (go) begin start = 1; go = 0; end
        else if (poke && !poked && r == 2) begin
          start = 1; chk_dq3 = 1; poked = 1;
        end
        req_prev = rd_req;
      end
    end
  end

  task automatic run(input bit c, input bit p0, input bit p1, input int n,
                     input int t, input int l, input bit pk);
    int kind, reads, lim;
    string otag, rtag;
    @(negedge clk);
    chk_mode = c; chk_dq3 = c; pre_v = p0; post_v = p1;
    rsp_n = n; rsp_t = t; rsp_off = c ? 2 : 0; lat = l;
    poke = pk; poked = 0; cmd_given = 0; cmd_wait = 0;
    r = 0; w = 0; ack_cyc = -100; ack1_cyc = -100; end_cyc = -1; rej_cyc = -1;
    got_done = 0; got_err = 0; got_rst = 0; got_rej = 0;
    gap_bad = 0; oe_bad = 0; pulse_bad = 0;
    go = 1;
    lim = 0;
    while (!(got_done || got_err) && lim < 3000) begin
      @(negedge clk); lim++;
    end
    if (lim >= 3000) check(0, "R4", "poll hung", lim, 0);
    @(negedge clk); @(negedge clk);
    chk_dq3 = 0;
    expect_run(n, t, kind, reads);
    otag = (kind == 0) ? ((t < NEVER) ? "R11" : "R4") : (kind == 1) ? "R6" : "R7";
    rtag = (t < NEVER) ? "R5" : "R4";
    check(got_done == (kind == 0) && got_err == (kind != 0) &&
          got_rst == (kind == 1), otag, "outcome",
          got_done ? 0 : (got_err ? (got_rst ? 1 : 2) : 3), kind);
    check(r == reads + rsp_off, pk ? "R9" : rtag, "read count", r, reads + rsp_off);
    check(end_cyc - ack_cyc == 2, "R4", "outcome delay", end_cyc - ack_cyc, 2);
    check(!gap_bad, "R3", "gap between reads", gap_bad, 0);
    check(!oe_bad, "R2", "oe/ce strobes", oe_bad, 0);
    check(!pulse_bad && ce_n, "R8", "single pulse then idle", pulse_bad, 0);
    if (c) begin
      check(got_rej == (p0 | p1), "R10", "erase_rej value", got_rej, p0 | p1);
      if (p0 | p1)
        check(rej_cyc - ack1_cyc == 1, "R10", "erase_rej delay",
              rej_cyc - ack1_cyc, 1);
    end else begin
      check(!got_rej, "R10", "erase_rej idle", got_rej, 0);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired: actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!rd_req && ce_n && oe_n && !done && !err && !rst_req && !erase_rej,
          "R1", "reset outputs", {rd_req, ce_n, oe_n, done, err, rst_req, erase_rej},
          7'b0110000);
    rst_n = 1;
    @(negedge clk);
    check(!rd_req && ce_n && oe_n && !done && !err, "R1", "after release",
          {rd_req, ce_n, oe_n, done, err}, 5'b01100);
    // R4 R7: toggle lengths and responder latency swept
    for (int l = 0; l < 3; l++)
      for (int n = 0; n < 10; n++)
        run(0, 0, 0, n, NEVER, l, 0);
    // R5 R6: time-limit flag arriving at each position while still toggling
    for (int t = 0; t < 10; t++)
      run(0, 0, 0, NEVER, t, 1, 0);
    // R5 R11: finish near the time limit
    for (int n = 2; n < 7; n++)
      for (int t = 0; t < 6; t++)
        run(0, 0, 0, n, t, 0, 0);
    // R10: all window-bit combinations
    for (int q = 0; q < 4; q++)
      run(1, q[0], q[1], 3, NEVER, q % 2, 0);
    // R9: start raised mid-poll
    run(0, 0, 0, 5, NEVER, 1, 1);
    run(0, 0, 0, NEVER, 3, 0, 1);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule